// File: doc/BRIEF.md
# Four-Master Rotating-Priority Bus Arbiter

This block shares one bus among four masters. Each master raises its request line for as long as it wants the bus. The arbiter answers with a one-hot grant vector. The grant register changes only on a rising clock edge. While the master that holds the grant is still requesting, the bus counts as busy and the grant does not move.

When the bus is free, the next edge grants the first requester in a circular search. The search starts at the master after the most recently recorded owner and ends at that owner. This gives every master equal access over time.

The recorded owner is kept in a small index register. That register is loaded by a one-cycle strobe from a two-bit edge-detect state machine. The state machine starts a sequence whenever some master requests while the bus is free. The block also gives out a binary form of the current grant, the busy flag, the recorded owner index and the load strobe.

Top module: `rr_arbiter`

## Requirements
- R1: No more than one bit of `gnt` is high in any cycle.
- R2: `busy` is high in exactly those cycles in which some master i has both `cyc[i]` and `gnt[i]` high. It follows `cyc` in the same cycle.
- R3: `gntIdx` is the binary index of the high `gnt` bit: 0001 gives 0, 0010 gives 1, 0100 gives 2 and 1000 gives 3. An all-zero `gnt` gives 0.
- R4: If `busy` is high and `rst` is low at a rising edge, `gnt` keeps its value across that edge.
- R5: If `busy` is low and `rst` is low at a rising edge, the edge grants the first requesting master in the order lastIdx+1, lastIdx+2, lastIdx+3, lastIdx (modulo 4). If no master requests, every grant bit goes low.
- R6: A start condition is defined as some `cyc` bit high while `busy` is low. The state machine behaves as follows:
  - From idle, a start condition moves it to the strobe state, where `loadPulse` is high for exactly one cycle.
  - From the strobe state it moves to a wait state if the start condition is still present, or back to idle if it is not.
  - The wait state returns to idle on the first cycle without a start condition.
- R7: At an edge that ends a cycle with `loadPulse` high, `lastIdx` takes the value `gntIdx` had in that cycle. At all other edges `lastIdx` holds its value.
- R8: A rising edge with `rst` high clears `gnt`, the state machine and `lastIdx` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cyc | input | 4 | Bus request, one line per master |
| gnt | output | 4 | Registered one-hot grant |
| busy | output | 1 | Granted master is still requesting |
| gntIdx | output | 2 | Binary index of the current grant |
| lastIdx | output | 2 | Recorded owner that sets the rotation start |
| loadPulse | output | 1 | One-cycle strobe that loads `lastIdx` |

## Verification
The assertions check several properties on every cycle:
- that the grant is one-hot or zero;
- that the grant is held across any busy edge;
- that a newly raised grant goes to a master that was requesting;
- that the load strobe never lasts two cycles;
- that `lastIdx` changes only at the edge after a strobe, and then to the grant index of that cycle;
- that reset clears the grant.

Some behaviour only the bench scenarios can show. The first is which requester wins for each stored owner value and each of the 15 request patterns. The second is that an empty request set releases the grant. The third is the exact cycle in which the strobe fires after a new arbitration. For these the bench compares every output with a cycle-accurate reference model over directed sweeps and random traffic.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
  typedef struct packed {
    logic busy;
    logic startReq;
    logic loadLast;
  } arb_strobe_t;
endpackage

// File: rtl/rr_arb_ctrl.sv
module rr_arb_ctrl
  import rr_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cyc,
  input  logic [N-1:0] gnt,
  output arb_strobe_t  strobe
);
  logic [N-1:0] ownVec;
  logic         busyC;
  logic         startC;
  logic         edgQ;
  logic         lasQ;

  // per-master ownership: still requesting and granted
  for (genvar i = 0; i < N; i++) begin : g_own
    assign ownVec[i] = cyc[i] & gnt[i];
  end

  assign busyC  = |ownVec;
  assign startC = (|cyc) & ~busyC;

  // two-bit edge detector: 00 -> 01 -> 10 (stay while start) -> 00
  always_ff @(posedge clk) begin
    if (rst) begin
      edgQ <= 1'b0;
      lasQ <= 1'b0;
    end else begin
      edgQ <= (startC & ~edgQ & lasQ) | (startC & edgQ & ~lasQ);
      lasQ <= startC & ~edgQ & ~lasQ;
    end
  end

  always_comb begin
    strobe.busy     = busyC;
    strobe.startReq = startC;
    strobe.loadLast = lasQ;
  end
endmodule

// File: rtl/rr_arb_dp.sv
module rr_arb_dp
  import rr_arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     cyc,
  input  arb_strobe_t      strobe,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gntIdx,
  output logic [IDX_W-1:0] lastIdx
);
  logic [N-1:0]     gntQ;
  logic [N-1:0]     pickD;
  logic [IDX_W-1:0] lastQ;
  logic [IDX_W-1:0] idxD;

  // circular search starting after the recorded owner
  always_comb begin
    logic found;
    logic [IDX_W-1:0] pos;
    found = 1'b0;
    pickD = '0;
    for (int k = 1; k <= N; k++) begin
      pos = IDX_W'((int'(lastQ) + k) % N);
      if (!found && cyc[pos]) begin
        pickD[pos] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  // encoder: OR of grant bits whose index has each bit set
  always_comb begin
    idxD = '0;
    for (int i = 0; i < N; i++) begin
      if (gntQ[i]) idxD = idxD | IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gntQ <= '0;
    end else if (!strobe.busy) begin
      gntQ <= pickD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastQ <= '0;
    end else if (strobe.loadLast) begin
      lastQ <= idxD;
    end
  end

  assign gnt     = gntQ;
  assign gntIdx  = idxD;
  assign lastIdx = lastQ;
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter
  import rr_arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     cyc,
  output logic [N-1:0]     gnt,
  output logic             busy,
  output logic [IDX_W-1:0] gntIdx,
  output logic [IDX_W-1:0] lastIdx,
  output logic             loadPulse
);
  arb_strobe_t strobe;

  rr_arb_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .cyc(cyc), .gnt(gnt), .strobe(strobe)
  );

  rr_arb_dp #(.N(N), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst(rst), .cyc(cyc), .strobe(strobe),
    .gnt(gnt), .gntIdx(gntIdx), .lastIdx(lastIdx)
  );

  assign busy      = strobe.busy;
  assign loadPulse = strobe.loadLast;
endmodule

// File: rtl/rr_arbiter_chk.sv
module rr_arbiter_chk #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     cyc,
  input logic [N-1:0]     gnt,
  input logic             busy,
  input logic [IDX_W-1:0] gntIdx,
  input logic [IDX_W-1:0] lastIdx,
  input logic             loadPulse
);
  assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_hold_busy_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> gnt == $past(gnt));

  assert_grant_to_requester_R5: assert property (@(posedge clk) disable iff (rst)
    ((gnt & ~$past(gnt)) != '0) |-> ((gnt & $past(cyc)) != '0));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    loadPulse |=> !loadPulse);

  assert_last_load_R7: assert property (@(posedge clk) disable iff (rst)
    loadPulse |=> lastIdx == $past(gntIdx));

  assert_last_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !loadPulse |=> $stable(lastIdx));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (gnt == '0 && lastIdx == '0 && !loadPulse));
endmodule

bind rr_arbiter rr_arbiter_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cyc(cyc), .gnt(gnt), .busy(busy),
  .gntIdx(gntIdx), .lastIdx(lastIdx), .loadPulse(loadPulse)
);

// File: tb/sim_rr_arbiter.sv
module sim_rr_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] cyc;
  logic [3:0] gnt;
  logic       busy;
  logic [1:0] gntIdx;
  logic [1:0] lastIdx;
  logic       loadPulse;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference model state
  logic [3:0] mGnt = '0;
  logic       mEdg = 1'b0;
  logic       mLas = 1'b0;
  logic [1:0] mLast = '0;
  bit         modelValid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_arbiter u0 (
    .clk(clk), .rst(rst), .cyc(cyc), .gnt(gnt), .busy(busy),
    .gntIdx(gntIdx), .lastIdx(lastIdx), .loadPulse(loadPulse)
  );

  function automatic logic [1:0] encIdx(input logic [3:0] g);
    case (g)
      4'b0010: return 2'd1;
      4'b0100: return 2'd2;
      4'b1000: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] rotPick(input logic [3:0] c, input logic [1:0] last);
    for (int k = 1; k <= 4; k++) begin
      int m;
      m = (int'(last) + k) % 4;
      if (c[m]) return 4'(1 << m);
    end
    return 4'b0000;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle: inputs at negedge, check at negedge+1, advance model
  task automatic step(input logic r, input logic [3:0] c);
    logic mBusy, beg;
    logic [1:0] mIdx;
    @(negedge clk);
    rst = r;
    cyc = c;
    #1;
    mBusy = |(c & mGnt);
    mIdx  = encIdx(mGnt);
    if (modelValid) begin
      check("R1 onehot", {3'b0, $countones(gnt) > 1}, 4'b0);
      check("R5 gnt", gnt, mGnt);
      check("R2 busy", {3'b0, busy}, {3'b0, mBusy});
      check("R3 gntIdx", {2'b0, gntIdx}, {2'b0, mIdx});
      check("R7 lastIdx", {2'b0, lastIdx}, {2'b0, mLast});
      check("R6 loadPulse", {3'b0, loadPulse}, {3'b0, mLas});
    end
    beg = (|c) & ~mBusy;
    if (r) begin
      mGnt = '0; mEdg = 0; mLas = 0; mLast = '0;
    end else begin
      logic nE, nL;
      if (mBusy) begin
        mGnt = mGnt;  // R4: held while busy
      end else begin
        mGnt = rotPick(c, mLast);
      end
      if (mLas) mLast = mIdx;
      nE = (beg & ~mEdg & mLas) | (beg & mEdg & ~mLas);
      nL = beg & ~mEdg & ~mLas;
      mEdg = nE;
      mLas = nL;
    end
    modelValid = 1;
  endtask

  initial begin
    logic [3:0] req;
    rst = 1'b1;
    cyc = '0;
    void'($urandom(32'd1234));
    step(1, 4'b0000);
    step(1, 4'b0000);
    // reset state, R8
    @(negedge clk); #1;
    check("R8 reset gnt", gnt, 4'b0000);
    check("R8 reset lastIdx", {2'b0, lastIdx}, 4'b0000);
    step(0, 4'b0000);
    // directed: master 0 then masters 1 and 2 together -> 1 wins (R5)
    step(0, 4'b0001); step(0, 4'b0001); step(0, 4'b0001);
    step(0, 4'b0110);
    step(0, 4'b0110);
    check("R5 rotation 0->1", gnt, 4'b0010);
    check("R6 pulse after grant", {3'b0, loadPulse}, 4'b0001);
    step(0, 4'b0110);
    check("R4 held while busy", gnt, 4'b0010);
    check("R7 last loaded", {2'b0, lastIdx}, 4'b0001);
    // exhaustive rotation sweep: every last value, every non-empty pattern (R5)
    for (int l = 0; l < 4; l++) begin
      for (int p = 1; p < 16; p++) begin
        step(0, 4'b0000);
        step(0, 4'(1 << l));
        step(0, 4'(1 << l));
        step(0, 4'b0000);
        check("R7 last set", {2'b0, lastIdx}, 4'(l));
        step(0, 4'(p));
        step(0, 4'(p));
        check("R5 sweep", gnt, rotPick(4'(p), 2'(l)));
      end
    end
    // empty requests release the grant (R5)
    step(0, 4'b0000);
    step(0, 4'b0000);
    check("R5 release", gnt, 4'b0000);
    // constrained random traffic with sticky requests
    req = '0;
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < 4; b++) begin
        if (($urandom % 4) == 0) req[b] = ~req[b];
      end
      step((($urandom % 250) == 0), req);
    end
    step(1, 4'b0000);
    step(0, 4'b0000);
    check("R8 reset after traffic", gnt, 4'b0000);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule